// File: doc/BRIEF.md
# Compact Branch Next-PC Unit

This unit resolves where a 64-bit core fetches next after a compact control-transfer instruction, that is, one with no delay slot. It takes the current program counter, a three-bit operation select, the index of the first source register and its value, the value of the second source register, and three raw immediates of 16, 21 and 26 bits. One clock later it reports the next program counter, whether this counts as a taken redirect, whether a return address must be written, and whether the operation select was not recognised.

A single operation code covers two forms. A nonzero source index makes it a branch when the register equals zero. A zero source index makes it a jump through the second register plus an unscaled offset. Both the long-offset branch and the register jump have a variant that links: it writes the address of the following instruction into register 31. Since the slot after the instruction is never executed, the link value is always pc + 4. All address arithmetic is 64 bits wide and wraps. Fetch, register file access and pipeline flushing stay with the surrounding core; this unit only reports the redirect.

Top module: `cbr_nextpc_unit`

## Requirements
- R1: While reset is asserted (rst_n low) and in the first cycle after it, out_valid, taken, link_we and illegal are 0, and next_pc, link_idx and link_val are 0.
- R2: Each output reflects the inputs sampled at the previous rising clock edge; out_valid equals the previous cycle's in_valid. When out_valid is 0, every other output is 0.
- R3: With opcode 3'b001 (long branch), next_pc = pc + 4 + (imm26 sign-extended from bit 25, times 4), and no link is written.
- R4: With opcode 3'b010 (long branch with link), next_pc is the same as in R3, link_we is 1, link_idx is 31 and link_val is pc + 4.
- R5: With opcode 3'b011 and a nonzero rs_idx, when rs_val is zero, next_pc = pc + 4 + (imm21 sign-extended from bit 20, times 4).
- R6: With opcode 3'b011, a nonzero rs_idx and a nonzero rs_val, next_pc = pc + 4 and taken is 0.
- R7: With opcode 3'b011 and rs_idx zero, next_pc = rt_val + imm16 sign-extended from bit 15, with no scaling and no link.
- R8: With opcode 3'b100 (register jump with link), next_pc = rt_val + sign-extended imm16, link_we is 1, link_idx is 31 and link_val is pc + 4.
- R9: taken is 1 exactly when out_valid is 1 and next_pc differs from pc + 4. This includes a zero offset and a register jump that lands on pc + 4, both of which give taken 0.
- R10: All sums wrap modulo 2^64, both above the top of the address space and below zero.
- R11: Any other opcode (3'b000, 3'b101, 3'b110, 3'b111) gives illegal = 1, next_pc = pc + 4, taken = 0 and link_we = 0.
- R12: When link_we is 0, link_idx and link_val are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| pc | input | 64 | Address of the instruction |
| opcode | input | 3 | Operation select (codes listed in R3 to R11) |
| rs_idx | input | 5 | Index field of the first source register |
| rs_val | input | 64 | Value of the first source register |
| rt_val | input | 64 | Value of the second source register |
| imm16 | input | 16 | Raw 16-bit immediate |
| imm21 | input | 21 | Raw 21-bit immediate |
| imm26 | input | 26 | Raw 26-bit immediate |
| out_valid | output | 1 | Result fields below are meaningful |
| next_pc | output | 64 | Address to fetch next |
| taken | output | 1 | next_pc leaves the sequential path |
| link_we | output | 1 | Write link_val to register link_idx |
| link_idx | output | 5 | Destination register of the link (31) |
| link_val | output | 64 | Return address, pc + 4 |
| illegal | output | 1 | The opcode is not one of the four known codes |

## Verification
The properties assume that pc, opcode, rs_idx and rs_val are defined whenever in_valid is high, and that rst_n is held low for at least one rising edge before any instruction arrives. The immediates and rt_val are not constrained; their effect is checked against the reference model only. The stimulus keeps every input at a known value from time zero. In idle cycles it still changes the data inputs, which shows that an invalid cycle produces nothing. The sign bit of each immediate is driven both ways, and pc values are placed near both ends of the address space so the wrap cases are reached.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
    localparam int OPC_W = 3;

    localparam logic [OPC_W-1:0] OPC_BRA  = 3'b001;
    localparam logic [OPC_W-1:0] OPC_BRAL = 3'b010;
    localparam logic [OPC_W-1:0] OPC_ZSEL = 3'b011;
    localparam logic [OPC_W-1:0] OPC_JRL  = 3'b100;
endpackage

// File: rtl/cbr_sext.sv
module cbr_sext #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 64
) (
    input  logic [IN_W-1:0]  raw,
    output logic [OUT_W-1:0] ext
);
    localparam int PAD_W = OUT_W - IN_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign ext = {{PAD_W{raw[IN_W-1]}}, raw};
        end else begin : g_nopad
            assign ext = raw[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/cbr_target_gen.sv
module cbr_target_gen #(
    parameter int XLEN = 64,
    parameter int INSN_BYTES = 4,
    parameter int WORD_SHIFT = 2
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rt_val,
    input  logic [XLEN-1:0] off16,
    input  logic [XLEN-1:0] off21,
    input  logic [XLEN-1:0] off26,
    output logic [XLEN-1:0] seq_pc,
    output logic [XLEN-1:0] tgt_long,
    output logic [XLEN-1:0] tgt_mid,
    output logic [XLEN-1:0] tgt_reg
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    always_comb begin
        seq_pc   = pc + STEP;
        tgt_long = seq_pc + (off26 << WORD_SHIFT);
        tgt_mid  = seq_pc + (off21 << WORD_SHIFT);
        tgt_reg  = rt_val + off16;
    end
endmodule

// File: rtl/cbr_nextpc_unit.sv
module cbr_nextpc_unit
    import cbr_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int RIDX_W   = 5,
    parameter int IMM_S_W  = 16,
    parameter int IMM_M_W  = 21,
    parameter int IMM_L_W  = 26,
    parameter int LINK_REG = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [XLEN-1:0]    pc,
    input  logic [OPC_W-1:0]   opcode,
    input  logic [RIDX_W-1:0]  rs_idx,
    input  logic [XLEN-1:0]    rs_val,
    input  logic [XLEN-1:0]    rt_val,
    input  logic [IMM_S_W-1:0] imm16,
    input  logic [IMM_M_W-1:0] imm21,
    input  logic [IMM_L_W-1:0] imm26,
    output logic               out_valid,
    output logic [XLEN-1:0]    next_pc,
    output logic               taken,
    output logic               link_we,
    output logic [RIDX_W-1:0]  link_idx,
    output logic [XLEN-1:0]    link_val,
    output logic               illegal
);
    localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(LINK_REG);

    typedef struct packed {
        logic              valid;
        logic [XLEN-1:0]   npc;
        logic              tkn;
        logic              lwe;
        logic [RIDX_W-1:0] lidx;
        logic [XLEN-1:0]   lval;
        logic              ill;
    } redir_t;

    logic [XLEN-1:0] off16, off21, off26;
    logic [XLEN-1:0] seq_pc, tgt_long, tgt_mid, tgt_reg;
    redir_t res_d, res_q;

    cbr_sext #(.IN_W(IMM_S_W), .OUT_W(XLEN)) u_sx16 (.raw(imm16), .ext(off16));
    cbr_sext #(.IN_W(IMM_M_W), .OUT_W(XLEN)) u_sx21 (.raw(imm21), .ext(off21));
    cbr_sext #(.IN_W(IMM_L_W), .OUT_W(XLEN)) u_sx26 (.raw(imm26), .ext(off26));

    cbr_target_gen #(.XLEN(XLEN)) u_tgt (
        .pc       (pc),
        .rt_val   (rt_val),
        .off16    (off16),
        .off21    (off21),
        .off26    (off26),
        .seq_pc   (seq_pc),
        .tgt_long (tgt_long),
        .tgt_mid  (tgt_mid),
        .tgt_reg  (tgt_reg)
    );

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.valid = 1'b1;
            res_d.npc   = seq_pc;
            unique case (opcode)
                OPC_BRA: begin
                    res_d.npc = tgt_long;
                end
                OPC_BRAL: begin
                    res_d.npc = tgt_long;
                    res_d.lwe = 1'b1;
                end
                OPC_ZSEL: begin
                    if (rs_idx != '0) begin
                        if (rs_val == '0) begin
                            res_d.npc = tgt_mid;
                        end
                    end else begin
                        res_d.npc = tgt_reg;
                    end
                end
                OPC_JRL: begin
                    res_d.npc = tgt_reg;
                    res_d.lwe = 1'b1;
                end
                default: begin
                    res_d.ill = 1'b1;
                end
            endcase
            res_d.tkn = (res_d.npc != seq_pc);
            if (res_d.lwe) begin
                res_d.lidx = LINK_IDX;
                res_d.lval = seq_pc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign next_pc   = res_q.npc;
    assign taken     = res_q.tkn;
    assign link_we   = res_q.lwe;
    assign link_idx  = res_q.lidx;
    assign link_val  = res_q.lval;
    assign illegal   = res_q.ill;
endmodule

// File: rtl/cbr_nextpc_unit_chk.sv
module cbr_nextpc_unit_chk
    import cbr_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int RIDX_W   = 5,
    parameter int LINK_REG = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [XLEN-1:0]   pc,
    input logic [OPC_W-1:0]  opcode,
    input logic [RIDX_W-1:0] rs_idx,
    input logic [XLEN-1:0]   rs_val,
    input logic              out_valid,
    input logic [XLEN-1:0]   next_pc,
    input logic              taken,
    input logic              link_we,
    input logic [RIDX_W-1:0] link_idx,
    input logic [XLEN-1:0]   link_val,
    input logic              illegal
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!taken && !link_we && !illegal && next_pc == '0));

    assert_link_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (opcode == OPC_BRAL || opcode == OPC_JRL)
        |=> link_we && link_idx == RIDX_W'(LINK_REG) && link_val == $past(pc) + STEP);

    assert_nolink_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !link_we |-> (link_idx == '0 && link_val == '0));

    assert_zero_fallthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && opcode == OPC_ZSEL && rs_idx != '0 && rs_val != '0
        |=> next_pc == $past(pc) + STEP && !taken && !link_we);

    assert_taken_meaning_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> taken == (next_pc != $past(pc) + STEP));

    assert_illegal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (out_valid && !taken && !link_we));
endmodule

bind cbr_nextpc_unit cbr_nextpc_unit_chk #(
    .XLEN(XLEN), .RIDX_W(RIDX_W), .LINK_REG(LINK_REG)
) u_chk (.*);

// File: tb/cbr_nextpc_unit_test.sv
module cbr_nextpc_unit_test;
    localparam int CLK_P = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    typedef struct {
        bit          v;
        logic [63:0] npc;
        bit          tk;
        bit          lwe;
        logic [4:0]  li;
        logic [63:0] lv;
        bit          ill;
        string       tag;
    } expect_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] pc = '0;
    logic [2:0]  opcode = '0;
    logic [4:0]  rs_idx = '0;
    logic [63:0] rs_val = '0;
    logic [63:0] rt_val = '0;
    logic [15:0] imm16 = '0;
    logic [20:0] imm21 = '0;
    logic [25:0] imm26 = '0;
    logic        out_valid, taken, link_we, illegal;
    logic [63:0] next_pc, link_val;
    logic [4:0]  link_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    expect_t pend[$];

    always #(CLK_P/2) clk = ~clk;

    cbr_nextpc_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc(pc), .opcode(opcode),
        .rs_idx(rs_idx), .rs_val(rs_val), .rt_val(rt_val), .imm16(imm16),
        .imm21(imm21), .imm26(imm26), .out_valid(out_valid), .next_pc(next_pc),
        .taken(taken), .link_we(link_we), .link_idx(link_idx), .link_val(link_val),
        .illegal(illegal)
    );

    function automatic longint signed_of(input logic [63:0] raw, input int bits);
        longint r = longint'(raw);
        if (raw[bits-1]) r = r - (longint'(1) <<< bits);
        return r;
    endfunction

    function automatic expect_t predict(input bit v, input logic [63:0] p, input logic [2:0] op,
                                        input logic [4:0] ri, input logic [63:0] rv,
                                        input logic [63:0] tv, input logic [15:0] i16,
                                        input logic [20:0] i21, input logic [25:0] i26,
                                        input string tag);
        expect_t e;
        logic [63:0] fall;
        e.v = 0; e.npc = '0; e.tk = 0; e.lwe = 0; e.li = '0; e.lv = '0; e.ill = 0; e.tag = tag;
        if (!v) return e;
        fall = p + 64'd4;
        e.v = 1;
        e.npc = fall;
        if (op == 3'b001 || op == 3'b010) begin
            e.npc = 64'(longint'(fall) + signed_of(64'(i26), 26) * 4);
            if (op == 3'b010) e.lwe = 1;
        end else if (op == 3'b011) begin
            if (ri == 0) e.npc = 64'(longint'(tv) + signed_of(64'(i16), 16));
            else if (rv == 0) e.npc = 64'(longint'(fall) + signed_of(64'(i21), 21) * 4);
        end else if (op == 3'b100) begin
            e.npc = 64'(longint'(tv) + signed_of(64'(i16), 16));
            e.lwe = 1;
        end else begin
            e.ill = 1;
        end
        e.tk = (e.npc != fall);
        if (e.lwe) begin
            e.li = 5'd31;
            e.lv = fall;
        end
        return e;
    endfunction

    task automatic compare(input expect_t e);
        checks++;
        if (out_valid !== e.v || next_pc !== e.npc || taken !== e.tk || link_we !== e.lwe ||
            link_idx !== e.li || link_val !== e.lv || illegal !== e.ill) begin
            errors++;
            $display("FAIL %s: actual v=%0b npc=%h tk=%0b lwe=%0b li=%0d lv=%h ill=%0b expected v=%0b npc=%h tk=%0b lwe=%0b li=%0d lv=%h ill=%0b",
                     e.tag, out_valid, next_pc, taken, link_we, link_idx, link_val, illegal,
                     e.v, e.npc, e.tk, e.lwe, e.li, e.lv, e.ill);
        end
    endtask

    task automatic step(input bit v, input logic [63:0] p, input logic [2:0] op,
                        input logic [4:0] ri, input logic [63:0] rv, input logic [63:0] tv,
                        input logic [15:0] i16, input logic [20:0] i21, input logic [25:0] i26,
                        input string tag);
        @(negedge clk);
        if (pend.size() > 0) compare(pend.pop_front());
        in_valid = v; pc = p; opcode = op; rs_idx = ri; rs_val = rv; rt_val = tv;
        imm16 = i16; imm21 = i21; imm26 = i26;
        pend.push_back(predict(v, p, op, ri, rv, tv, i16, i21, i26, tag));
    endtask

    initial begin
        expect_t z;
        z = predict(0, '0, '0, '0, '0, '0, '0, '0, '0, "R1");
        repeat (3) @(negedge clk);
        compare(z);                                   // R1 during reset
        @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare(z);                                   // R1 after release
        // R3 long branch, positive / negative / zero offset
        step(1, 64'h1000, 3'b001, 5'd0, 64'd0, 64'd0, 16'h0, 21'h0, 26'h0000010, "R3");
        step(1, 64'h1000, 3'b001, 5'd0, 64'd0, 64'd0, 16'h0, 21'h0, 26'h3FFFFFF, "R3");
        step(1, 64'h2000, 3'b001, 5'd0, 64'd0, 64'd0, 16'h0, 21'h0, 26'h0, "R9");
        // R4 long branch with link
        step(1, 64'h4000_0000, 3'b010, 5'd0, 64'd0, 64'd0, 16'h0, 21'h0, 26'h2000000, "R4");
        // R5 branch-if-zero taken, both signs
        step(1, 64'h8000, 3'b011, 5'd7, 64'd0, 64'd99, 16'h7, 21'h000100, 26'h0, "R5");
        step(1, 64'h8000, 3'b011, 5'd1, 64'd0, 64'd99, 16'h7, 21'h100000, 26'h0, "R5");
        // R6 branch-if-zero not taken
        step(1, 64'h8000, 3'b011, 5'd31, 64'd5, 64'd99, 16'h7, 21'h000100, 26'h5, "R6");
        // R7 register jump, no scaling, negative immediate
        step(1, 64'h8000, 3'b011, 5'd0, 64'd5, 64'h1_0000, 16'hFFFF, 21'h1, 26'h1, "R7");
        step(1, 64'h8000, 3'b011, 5'd0, 64'd0, 64'h8001, 16'h0003, 21'h1, 26'h1, "R9");
        // R8 register jump with link
        step(1, 64'hC000, 3'b100, 5'd9, 64'd1, 64'h7000, 16'h8000, 21'h0, 26'h0, "R8");
        // R10 wraparound
        step(1, 64'hFFFF_FFFF_FFFF_FFF8, 3'b001, 5'd0, 64'd0, 64'd0, 16'h0, 21'h0, 26'h4, "R10");
        step(1, 64'h10, 3'b011, 5'd3, 64'd0, 64'd0, 16'h0, 21'h1FFFF0, 26'h0, "R10");
        step(1, 64'h10, 3'b100, 5'd0, 64'd0, 64'h2, 16'hFFF0, 21'h0, 26'h0, "R10");
        // R11 unknown codes
        for (int k = 0; k < 8; k++) begin
            if (k >= 1 && k <= 4) continue;
            step(1, 64'h3000 + 64'(k), 3'(k), 5'd4, 64'd0, 64'h5555, 16'h1234, 21'h1234, 26'h1234, "R11");
        end
        // R2 / R12 idle cycles with busy data inputs
        step(0, 64'h1234, 3'b010, 5'd0, 64'd0, 64'h9999, 16'h1, 21'h1, 26'h1, "R2");
        step(1, 64'h5000, 3'b001, 5'd0, 64'd0, 64'd0, 16'h0, 21'h0, 26'h8, "R12");
        step(0, 64'h1234, 3'b100, 5'd0, 64'd0, 64'h9999, 16'h1, 21'h1, 26'h1, "R2");
        // mixed stream
        for (int n = 0; n < 400; n++) begin
            logic [63:0] rp;
            rp = {$urandom, $urandom};
            if (n % 5 == 0) rp = 64'hFFFF_FFFF_FFFF_FF00 + 64'($urandom_range(0, 255));
            step($urandom_range(0, 3) != 0, rp, 3'($urandom_range(0, 7)),
                 ($urandom_range(0, 2) == 0) ? 5'd0 : 5'($urandom),
                 ($urandom_range(0, 1) == 0) ? 64'd0 : {$urandom, $urandom},
                 {$urandom, $urandom}, 16'($urandom), 21'($urandom), 26'($urandom), "R9");
        end
        step(0, '0, '0, '0, '0, '0, '0, '0, '0, "R2");
        @(negedge clk);
        compare(pend.pop_front());
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule